// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-memory protocol controller and the storage array of a byte-wide nonvolatile memory. The controller opens a page with a start strobe that carries a 15-bit byte address. It then hands over data bytes one at a time and signals the end of the transfer with a stop strobe. The block keeps the bytes in a page latch of 64 slots. Each byte goes to the slot that the low six address bits select. Those six bits advance after every byte and wrap inside the page, so the page stays fixed.

On stop, and only if at least one byte was latched, the block enters a self-timed commit. For a fixed number of system clocks it holds busy high and writes every filled slot to the array at the page base plus the slot index. An abort, or a stop with no bytes, discards the latch without a commit. While busy, new page or byte strobes are ignored. The block also returns the address that follows the last latched byte, so the controller can use it as its current address.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the latch holds no bytes.
- R2: A `pg_start` pulse while not busy opens a page and clears the latch. From the next cycle, `cur_addr` equals `pg_addr`.
- R3: Each accepted `byte_vld` stores `byte_data` in the slot `cur_addr[5:0]` and then adds one to `cur_addr[5:0]` modulo 64. `cur_addr[14:6]` does not change.
- R4: When more than 64 bytes arrive in one page, the slot index wraps. A later byte replaces the earlier byte in the same slot, and only the newest value is committed.
- R5: A `stop_seen` pulse with at least one byte latched raises `busy` in the next cycle. `busy` then stays high for exactly `COMMIT_CLKS` consecutive cycles.
- R6: During a commit, each filled slot s produces one `mem_we` cycle with `mem_addr = {cur_addr[14:6], s}` and its latched byte. The writes come in ascending slot order. Empty slots produce no write, and no write happens while `busy` is low.
- R7: `abort_req`, or a `stop_seen` with no byte latched, returns the block to idle, clears the latch and starts no commit.
- R8: After a stop, `cur_addr` holds the last written in-page address plus one, wrapped within the page.
- R9: While `busy` is high, `pg_start`, `byte_vld` and `stop_seen` have no effect. `cur_addr` stays unchanged, and no extra writes follow.
- R10: A page holding a single byte commits exactly one array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_start | input | 1 | Opens a page at `pg_addr` |
| pg_addr | input | 15 | Start byte address of the page transfer |
| byte_vld | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte from the controller |
| stop_seen | input | 1 | End of the write transfer; triggers the commit |
| abort_req | input | 1 | Drops the open page without committing |
| busy | output | 1 | Commit cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 15 | Array write address |
| mem_data | output | 8 | Array write data |
| cur_addr | output | 15 | Page base and next in-page address |

## Verification
Every strobe is registered once. `cur_addr` therefore shows the effect of a start or byte one cycle after the strobe, and `busy` rises one cycle after `stop_seen`. The first array write (slot 0, if filled) appears in that same first busy cycle. Slot s is written in busy cycle s+1, and `busy` falls after `COMMIT_CLKS` cycles. The bench drives strobes on the falling edge and samples on the following falling edge, so each result is read one full cycle after the edge that produced it. A scoreboard queue, built from a model of the page at stop time, absorbs the writes in order whatever their cycle spacing. The busy length is counted cycle by cycle against the parameter.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int unsigned PGW_ADDR_W = 15;
    localparam int unsigned PGW_OFS_W  = 6;
    localparam int unsigned PGW_DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2
    } pgw_state_e;

    // next slot index inside a page, wrapping at the page size
    function automatic logic [PGW_OFS_W-1:0] slot_next(input logic [PGW_OFS_W-1:0] s);
        return s + 1'b1;
    endfunction

endpackage

// File: rtl/pgw_latch.sv
module pgw_latch #(
    parameter int unsigned OFS_W  = 6,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int unsigned SLOTS = 1 << OFS_W;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  fill_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_q <= '0;
        end else if (wr_en) begin
            fill_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data   = slot_q[rd_idx];
    assign rd_valid  = fill_q[rd_idx];
    assign any_valid = |fill_q;
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
    parameter int unsigned LEN   = 80,
    parameter int unsigned CNT_W = $clog2(LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             running,
    output logic             last,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count   <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            count   <= '0;
        end else if (running) begin
            if (count == LAST_VAL) begin
                running <= 1'b0;
                count   <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign last = running && (count == LAST_VAL);
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
    import pgw_pkg::*;
#(
    parameter int unsigned ADDR_W      = PGW_ADDR_W,
    parameter int unsigned OFS_W       = PGW_OFS_W,
    parameter int unsigned DATA_W      = PGW_DATA_W,
    parameter int unsigned COMMIT_CLKS = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_start,
    input  logic [ADDR_W-1:0] pg_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_seen,
    input  logic              abort_req,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int unsigned BASE_W = ADDR_W - OFS_W;
    localparam int unsigned SLOTS  = 1 << OFS_W;
    localparam int unsigned CNT_W  = $clog2(COMMIT_CLKS + 1);

    pgw_state_e        state_q;
    logic [BASE_W-1:0] base_q;
    logic [OFS_W-1:0]  ptr_q;

    logic              t_start, t_run, t_last;
    logic [CNT_W-1:0]  t_cnt;
    logic              l_clr, l_wr, l_rd_valid, l_any;
    logic [DATA_W-1:0] l_rd_data;
    logic [OFS_W-1:0]  scan_idx;
    logic              scan_on;

    // control decode
    always_comb begin
        t_start = 1'b0;
        l_clr   = 1'b0;
        l_wr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                l_clr = pg_start || abort_req;
            end
            ST_FILL: begin
                if (abort_req) begin
                    l_clr = 1'b1;
                end else if (stop_seen) begin
                    t_start = l_any;
                    l_clr   = !l_any;
                end else if (pg_start) begin
                    l_clr = 1'b1;
                end else begin
                    l_wr = byte_vld;
                end
            end
            ST_COMMIT: begin
                l_clr = t_last;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pg_start && !abort_req) begin
                        state_q <= ST_FILL;
                        base_q  <= pg_addr[ADDR_W-1:OFS_W];
                        ptr_q   <= pg_addr[OFS_W-1:0];
                    end
                end
                ST_FILL: begin
                    if (abort_req) begin
                        state_q <= ST_IDLE;
                    end else if (stop_seen) begin
                        state_q <= l_any ? ST_COMMIT : ST_IDLE;
                    end else if (pg_start) begin
                        base_q <= pg_addr[ADDR_W-1:OFS_W];
                        ptr_q  <= pg_addr[OFS_W-1:0];
                    end else if (byte_vld) begin
                        ptr_q <= slot_next(ptr_q);
                    end
                end
                ST_COMMIT: begin
                    if (t_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    pgw_latch #(
        .OFS_W (OFS_W),
        .DATA_W(DATA_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .clr      (l_clr),
        .wr_en    (l_wr),
        .wr_idx   (ptr_q),
        .wr_data  (byte_data),
        .rd_idx   (scan_idx),
        .rd_data  (l_rd_data),
        .rd_valid (l_rd_valid),
        .any_valid(l_any)
    );

    pgw_timer #(
        .LEN  (COMMIT_CLKS),
        .CNT_W(CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (t_start),
        .running(t_run),
        .last   (t_last),
        .count  (t_cnt)
    );

    // slot scan runs over the first SLOTS cycles of the commit window
    generate
        if (COMMIT_CLKS >= SLOTS) begin : g_scan_fit
            assign scan_on = t_run && (t_cnt < CNT_W'(SLOTS));
        end else begin : g_scan_short
            assign scan_on = t_run;
        end
    endgenerate

    assign scan_idx = t_cnt[OFS_W-1:0];
    assign busy     = (state_q == ST_COMMIT);
    assign mem_we   = busy && scan_on && l_rd_valid;
    assign mem_addr = {base_q, scan_idx};
    assign mem_data = l_rd_data;
    assign cur_addr = {base_q, ptr_q};
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int unsigned ADDR_W      = 15,
    parameter int unsigned COMMIT_CLKS = 80
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_seen,
    input logic              abort_req,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam int unsigned RUN_W = $clog2(COMMIT_CLKS + 2);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1'b1;
    end

    p_we_inside_commit_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_seen));

    p_busy_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RUN_W'(COMMIT_CLKS)));

    p_busy_full_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == RUN_W'(COMMIT_CLKS)));

    p_abort_no_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (abort_req && !busy) |=> !busy);

    p_addr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_addr));
endmodule

bind eeprom_page_commit pgw_checker #(
    .ADDR_W     (ADDR_W),
    .COMMIT_CLKS(COMMIT_CLKS)
) u_pgw_checker (
    .clk      (clk),
    .rst      (rst),
    .stop_seen(stop_seen),
    .abort_req(abort_req),
    .busy     (busy),
    .mem_we   (mem_we),
    .cur_addr (cur_addr)
);

// File: tb/test_eeprom_page_commit.sv
module test_eeprom_page_commit;
    localparam int unsigned CLKS = 80;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg_start = 1'b0;
    logic [14:0] pg_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_seen = 1'b0;
    logic        abort_req = 1'b0;
    logic        busy, mem_we;
    logic [14:0] mem_addr, cur_addr;
    logic [7:0]  mem_data;

    int tests = 0;
    int fails = 0;

    // bench model of the page
    logic [7:0]  m_data [64];
    logic [63:0] m_fill = '0;
    logic [8:0]  m_base = '0;
    logic [5:0]  m_ptr  = '0;
    logic [22:0] exp_q [$];

    always #2 clk = ~clk;

    eeprom_page_commit #(.COMMIT_CLKS(CLKS)) i_eeprom_page_commit (
        .clk(clk), .rst(rst), .pg_start(pg_start), .pg_addr(pg_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_seen(stop_seen),
        .abort_req(abort_req), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .cur_addr(cur_addr)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every array write must match the head of the queue
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R9 unexpected write", {mem_addr, mem_data}, 0);
            end else begin
                logic [22:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_data} == e, "R6 write", {mem_addr, mem_data}, e);
            end
        end
    end

    task automatic open_page(input logic [14:0] a, input logic live);
        @(negedge clk); pg_start = 1'b1; pg_addr = a;
        @(negedge clk); pg_start = 1'b0;
        if (live) begin
            m_fill = '0; m_base = a[14:6]; m_ptr = a[5:0];
            chk(cur_addr == a, "R2 cur_addr after start", cur_addr, a);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input logic live);
        @(negedge clk); byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
        if (live) begin
            m_data[m_ptr] = d; m_fill[m_ptr] = 1'b1; m_ptr = m_ptr + 1'b1;
        end
    endtask

    task automatic stop_commit;
        int n;
        for (int s = 0; s < 64; s++)
            if (m_fill[s]) exp_q.push_back({m_base, 6'(s), m_data[s]});
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        chk(busy == 1'b1, "R5 busy one cycle after stop", busy, 1);
        n = 0;
        while (busy && n < 10 * CLKS) begin
            n++;
            @(negedge clk);
        end
        chk(n == CLKS, "R5 busy length", n, CLKS);
        chk(exp_q.size() == 0, "R6 all filled slots written", exp_q.size(), 0);
        chk(cur_addr == {m_base, m_ptr}, "R8 next address", cur_addr, {m_base, m_ptr});
        m_fill = '0;
    endtask

    task automatic expect_idle(input string req);
        int hi;
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
        chk(hi == 0, req, hi, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(mem_we == 1'b0, "R1 mem_we after reset", mem_we, 0);

        // R2 R3 R8: three bytes inside a page
        open_page(15'h1234, 1'b1);
        put_byte(8'hA1, 1'b1);
        put_byte(8'hB2, 1'b1);
        put_byte(8'hC3, 1'b1);
        chk(cur_addr == 15'h1237, "R3 offset advance", cur_addr, 15'h1237);
        stop_commit();

        // R3 R4: 66 bytes from offset 62, wrap and overwrite
        open_page(15'h2BFE, 1'b1);
        for (int i = 0; i < 66; i++) put_byte(8'(i + 16), 1'b1);
        chk(cur_addr == 15'h2BC0, "R3 wrap keeps upper bits", cur_addr, 15'h2BC0);
        stop_commit();

        // R7: stop with no bytes
        open_page(15'h0100, 1'b1);
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        expect_idle("R7 empty stop no commit");

        // R7: abort discards bytes; R10: next page with one byte writes once
        open_page(15'h0200, 1'b1);
        put_byte(8'h55, 1'b1);
        put_byte(8'h66, 1'b1);
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        expect_idle("R7 abort no commit");
        open_page(15'h0240, 1'b1);
        put_byte(8'h77, 1'b1);
        stop_commit();

        // R9: strobes while busy are ignored
        open_page(15'h4010, 1'b1);
        put_byte(8'h9C, 1'b1);
        for (int s = 0; s < 64; s++)
            if (m_fill[s]) exp_q.push_back({m_base, 6'(s), m_data[s]});
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        @(negedge clk); pg_start = 1'b1; pg_addr = 15'h7000;
        @(negedge clk); pg_start = 1'b0; byte_vld = 1'b1; byte_data = 8'hEE;
        @(negedge clk); byte_vld = 1'b0; stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        chk(cur_addr == 15'h4011, "R9 cur_addr frozen", cur_addr, 15'h4011);
        while (busy) @(negedge clk);
        expect_idle("R9 no second commit");
        chk(exp_q.size() == 0, "R9 only original byte written", exp_q.size(), 0);
        m_fill = '0;

        // R10 R8: single byte at top address, offset wraps to page start
        open_page(15'h7FFF, 1'b1);
        put_byte(8'h3D, 1'b1);
        chk(cur_addr == 15'h7FC0, "R8 wrap at top", cur_addr, 15'h7FC0);
        stop_commit();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule